// File: doc/BRIEF.md
# Two-Stage Pulse Conditioning Filter

This block cleans up a single slow control or trigger line that has already been sampled into the system clock domain. It has two stages in series. The first stage is a width gate. A new level is accepted only once it has persisted for a minimum number of cycles, and that minimum is set separately for high and for low. A pulse that passes the gate keeps its shape. Its rising edge is delayed by the high minimum less one cycle, and its falling edge by the low minimum less one cycle. The second stage is a post-edge hold. Once the gated signal changes level, the output is frozen at the new level for a set number of cycles, again set separately for each polarity. This hides chatter that follows a real edge.

All four lengths are compile-time parameters. A value of 1 turns the matching stage into a plain wire, with no delay and no register. The default setting for conditioned control lines is 1/1 for the width gate and 4/4 for the hold, so only the hold stage is active. An active-low asynchronous reset clears every register. While reset is low, the output is also forced to 0.

Top module: `glitch_filter`

## Requirements
- R1: With all four lengths set to 1, `filt_o` equals `raw_i` in the same cycle.
- R2: With the width gate active (MIN_HI_W > 1), a high run on `raw_i` shorter than MIN_HI_W cycles never reaches `filt_o`, and `filt_o` rises only while `raw_i` is 1.
- R3: With the width gate active (MIN_LO_W > 1), a low run on `raw_i` shorter than MIN_LO_W cycles never reaches `filt_o`, and `filt_o` falls only while `raw_i` is 0.
- R4: An accepted rising edge appears MIN_HI_W-1 cycles after the input edge. An accepted falling edge appears MIN_LO_W-1 cycles after the input edge. With equal minima, pulse length is preserved.
- R5: After a rising edge, `filt_o` stays 1 for at least KEEP_HI cycles, whatever the input does.
- R6: After a falling edge, `filt_o` stays 0 for at least KEEP_LO cycles, whatever the input does.
- R7: In the first cycle after a hold ends, `filt_o` takes the current width-gate value. If that value differs, it starts a new edge and a new hold.
- R8: The width gate acts before the hold. A glitch removed by the gate is never stretched by the hold.
- R9: While `rst_ni` is 0, `filt_o` is 0 and all counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Input line, already sampled in the clock domain |
| filt_o | output | 1 | Conditioned output |

## Verification
The delicate cycle is the one in which a hold period expires at the same moment the width gate presents a level that differs from the held one. The hold must release on that cycle and re-arm at once, not one cycle later. This is provoked by driving a rising input edge exactly on the last cycle of a low hold. The default 4/4-hold instance then has to rise on the very next cycle. The 2/2-gate, 3/3-hold instance is given a gated edge that lands right as its hold counter reaches zero, so it is judged in the same way. Both are checked cycle by cycle against hand-derived expected sequences.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

  function automatic int unsigned bits_for(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/glitch_width_stage.sv
module glitch_width_stage
  import glitch_pkg::*;
#(
  parameter int unsigned MIN_HI = 1,
  parameter int unsigned MIN_LO = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  generate
    if (MIN_HI <= 1 && MIN_LO <= 1) begin : g_pass
      assign q_o = d_i;
    end else begin : g_filt
      localparam int unsigned RunMax = max2(MIN_HI, MIN_LO);
      localparam int unsigned CW     = bits_for(RunMax);
      localparam logic [CW-1:0] NeedHi = CW'(MIN_HI);
      localparam logic [CW-1:0] NeedLo = CW'(MIN_LO);

      logic          lvl_q;
      logic [CW-1:0] run_q;
      logic [CW-1:0] run_nx;
      logic          flip;

      always_comb begin
        run_nx = run_q + CW'(1);
        flip   = (d_i != lvl_q) && (run_nx >= (d_i ? NeedHi : NeedLo));
      end

      // accepted level is shown in the cycle the run completes
      assign q_o = flip ? d_i : lvl_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lvl_q <= 1'b0;
          run_q <= '0;
        end else if (flip) begin
          lvl_q <= d_i;
          run_q <= '0;
        end else if (d_i != lvl_q) begin
          run_q <= run_nx;
        end else begin
          run_q <= '0;
        end
      end

      assert_run_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q < CW'(RunMax));
    end
  endgenerate

  assert_rise_needs_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> d_i);

  assert_fall_needs_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(q_o) |-> !d_i);

endmodule

// File: rtl/glitch_hold_stage.sv
module glitch_hold_stage
  import glitch_pkg::*;
#(
  parameter int unsigned KEEP_HI = 4,
  parameter int unsigned KEEP_LO = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  generate
    if (KEEP_HI <= 1 && KEEP_LO <= 1) begin : g_pass
      assign q_o = d_i;
    end else begin : g_hold
      localparam int unsigned HoldMax = max2(KEEP_HI, KEEP_LO);
      localparam int unsigned HW      = bits_for(HoldMax);
      localparam logic [HW-1:0] LoadHi = HW'(KEEP_HI - 1);
      localparam logic [HW-1:0] LoadLo = HW'(KEEP_LO - 1);

      logic          prev_q;
      logic [HW-1:0] hold_q;

      assign q_o = (hold_q != '0) ? prev_q : d_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          hold_q <= '0;
        end else begin
          prev_q <= q_o;
          if (q_o != prev_q) begin
            hold_q <= q_o ? LoadHi : LoadLo;
          end else if (hold_q != '0) begin
            hold_q <= hold_q - HW'(1);
          end
        end
      end

      assert_hold_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_q < HW'(HoldMax));
    end
  endgenerate

  assert_follow_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o != $past(q_o)) |-> (q_o == d_i));

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import glitch_pkg::*;
#(
  parameter int unsigned MIN_HI_W = 1,
  parameter int unsigned MIN_LO_W = 1,
  parameter int unsigned KEEP_HI  = 4,
  parameter int unsigned KEEP_LO  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);

  logic width_q;
  logic hold_q;

  glitch_width_stage #(
    .MIN_HI (MIN_HI_W),
    .MIN_LO (MIN_LO_W)
  ) u_width (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (width_q)
  );

  glitch_hold_stage #(
    .KEEP_HI (KEEP_HI),
    .KEEP_LO (KEEP_LO)
  ) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (width_q),
    .q_o    (hold_q)
  );

  assign filt_o = rst_ni & hold_q;

  // independent edge-age tracker for hold checks
  localparam int unsigned AgeMax = max2(KEEP_HI, KEEP_LO);
  localparam int unsigned AW     = bits_for(AgeMax);

  logic [AW-1:0] age_q;
  logic          last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q  <= AW'(AgeMax);
      last_q <= 1'b0;
    end else begin
      last_q <= filt_o;
      if (filt_o != last_q) begin
        age_q <= AW'(1);
      end else if (age_q < AW'(AgeMax)) begin
        age_q <= age_q + AW'(1);
      end
    end
  end

  assert_keep_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_q && !filt_o) |-> (age_q >= AW'(KEEP_HI)));

  assert_keep_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!last_q && filt_o) |-> (age_q >= AW'(KEEP_LO)));

endmodule

// File: tb/glitch_filter_bench.sv
`timescale 1ns/1ps
module glitch_filter_bench;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic raw = 1'b0;
  logic out_a, out_b, out_c, out_d;
  int   n_tests = 0;
  int   n_fail  = 0;

  always #10 clk = ~clk;

  // A: default (gate 1/1, hold 4/4)
  glitch_filter u_glitch_filter (
    .clk_i (clk), .rst_ni (rst_ni), .raw_i (raw), .filt_o (out_a)
  );
  // B: gate 2/3, no hold
  glitch_filter #(.MIN_HI_W(2), .MIN_LO_W(3), .KEEP_HI(1), .KEEP_LO(1)) u_glitch_filter_b (
    .clk_i (clk), .rst_ni (rst_ni), .raw_i (raw), .filt_o (out_b)
  );
  // C: gate 2/2, hold 3/3
  glitch_filter #(.MIN_HI_W(2), .MIN_LO_W(2), .KEEP_HI(3), .KEEP_LO(3)) u_glitch_filter_c (
    .clk_i (clk), .rst_ni (rst_ni), .raw_i (raw), .filt_o (out_c)
  );
  // D: all lengths 1
  glitch_filter #(.MIN_HI_W(1), .MIN_LO_W(1), .KEEP_HI(1), .KEEP_LO(1)) u_glitch_filter_d (
    .clk_i (clk), .rst_ni (rst_ni), .raw_i (raw), .filt_o (out_d)
  );

  task automatic chk(string req, string inst, int cyc, logic got, logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s inst %s cycle %0d: got %0b expected %0b", req, inst, cyc, got, exp);
    end
  endtask

  task automatic run_case(string req, string din, string ea, string eb, string ec, string ed);
    for (int t = 0; t < din.len(); t++) begin
      @(negedge clk);
      raw = (din[t] == "1");
      #5;
      chk(req, "A", t, out_a, ea[t] == "1");
      chk(req, "B", t, out_b, eb[t] == "1");
      chk(req, "C", t, out_c, ec[t] == "1");
      chk(req, "D", t, out_d, ed[t] == "1");
    end
  endtask

  // R9: reset forces output low even with input high
  task automatic test_reset(logic din);
    @(negedge clk);
    rst_ni = 1'b0;
    raw    = din;
    for (int k = 0; k < 2; k++) begin
      #5;
      chk("R9", "A", k, out_a, 1'b0);
      chk("R9", "B", k, out_b, 1'b0);
      chk("R9", "C", k, out_c, 1'b0);
      chk("R9", "D", k, out_d, 1'b0);
      @(negedge clk);
    end
    rst_ni = 1'b1;
    raw    = 1'b0;
  endtask

  // R1 passthrough, R5/R6 holds, R8 gate-before-hold, R2 short highs dropped
  task automatic test_hold_and_order();
    test_reset(1'b1);
    run_case("R1/R2/R5/R6/R8",
             "0101111000100000",
             "0111111000000000",
             "0000111110000000",
             "0000111100000000",
             "0101111000100000");
  endtask

  // R3 short lows dropped, R4 edge latency, R7 hold release into new edge
  task automatic test_width_and_release();
    test_reset(1'b0);
    run_case("R3/R4/R7",
             "0011011110001101100000",
             "0011111110000111100000",
             "0001111111100111111000",
             "0001111111000111110000",
             "0011011110001101100000");
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    test_reset(1'b0);
    test_hold_and_order();
    test_width_and_release();
    test_reset(1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule